// File: doc/BRIEF.md
# Data Memory Address Generator

This block forms the 12-bit data-memory address for an 8-bit accumulator core from the operand fields of the instruction being executed. It takes the 8-bit file field, the bank/access selector bit, a 4-bit bank register, three 12-bit pointer registers, a request for pointer-indirect access, and a configuration bit that turns on the extended instruction set. It produces the effective address, a 2-bit code naming the addressing mode that was chosen, and a valid flag.

With the extended set off, an access-selected operand maps to the low or high part of the access window. With the extended set on, an access-selected operand whose file field is 5Fh or less becomes a literal offset added to pointer 2. Operands at 60h and above keep the normal access mapping. Banked operands, and indirect accesses through any pointer, do not depend on the configuration bit.

The address logic is combinational. Its result is captured in output registers on each clock edge where the instruction strobe is high. Instruction decode, the RAM and the pointer post-increment effects belong to neighbouring blocks.

Top module: `dm_addr_gen`

## Requirements
- R1: While reset is held and after it is released, with no strobe, `ea_valid` is 0, `ea_addr` is 000h and `ea_mode` is 0.
- R2: With `op_ind`=0 and `op_bank`=1, the address is {`bank_reg`, `op_file`} and the mode is 0 (banked), whatever the value of `cfg_ext`. Mode codes: 0 banked, 1 access, 2 indexed offset, 3 indirect.
- R3: An access operand (`op_ind`=0, `op_bank`=0) that is not indexed maps file 00h–5Fh to 000h–05Fh and file 60h–FFh to F60h–FFFh, with mode 1. A file field of 60h or above always takes this mapping, even with `cfg_ext`=1.
- R4: With `cfg_ext`=1, `op_ind`=0, `op_bank`=0 and `op_file` ≤ 5Fh, the address is `ptr2` plus the zero-extended file field modulo 4096, and the mode is 2.
- R5: With `cfg_ext`=0 the mode is never 2.
- R6: With `op_ind`=1 the address is the pointer chosen by `op_ind_sel` (0 → `ptr0`, 1 → `ptr1`, 2 and 3 → `ptr2`) and the mode is 3. `cfg_ext`, `op_bank` and `op_file` have no effect.
- R7: A strobe with `op_nomem`=1 clears `ea_valid` and leaves `ea_addr` and `ea_mode` unchanged.
- R8: With `op_strb`=0, all three outputs keep their values, whatever the other inputs do.
- R9: A strobe with `op_nomem`=0 sets `ea_valid` to 1. The new address and mode appear on the outputs after the same clock edge.
- R10: The priority is: no-operand first, then indirect, then banked, then indexed, then access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_strb | input | 1 | Instruction-cycle capture strobe |
| op_nomem | input | 1 | The instruction has no data-memory operand |
| op_ind | input | 1 | Pointer-indirect access request |
| op_ind_sel | input | 2 | Pointer index for indirect access |
| op_file | input | 8 | File field of the instruction |
| op_bank | input | 1 | 1 = banked operand, 0 = access operand |
| cfg_ext | input | 1 | Extended instruction set enable |
| bank_reg | input | 4 | Bank select register |
| ptr0 | input | 12 | Pointer register 0 |
| ptr1 | input | 12 | Pointer register 1 |
| ptr2 | input | 12 | Pointer register 2 |
| ea_addr | output | 12 | Registered effective address |
| ea_mode | output | 2 | Registered addressing-mode code |
| ea_valid | output | 1 | Registered operand-present flag |

## Verification
The bench builds the block with its default parameters: a 12-bit address split into a 4-bit bank and an 8-bit file, the access split at 60h, and the indexed path present. These values make the full 12-bit offset wraparound reachable: pointer 2 near FFFh plus a small offset yields a low address. They also make both edges of the indexed window reachable, at 5Fh and 60h. Because every pointer is a full 12 bits wide, the bench can give the three pointers distinct values, so a wrong pointer selection shows up in the address.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

   typedef enum logic [1:0] {
      M_BANK = 2'd0,
      M_ACC  = 2'd1,
      M_IDX  = 2'd2,
      M_IND  = 2'd3
   } ea_mode_e;

endpackage

// File: rtl/dmag_direct_map.sv
module dmag_direct_map #(
   parameter int FILE_W    = 8,
   parameter int BANK_W    = 4,
   parameter int ACC_SPLIT = 'h60
) (
   input  logic [FILE_W-1:0]        file_i,
   input  logic [BANK_W-1:0]        bank_i,
   input  logic                     bank_sel_i,
   output logic [BANK_W+FILE_W-1:0] addr_o
);
   localparam int                ADDR_W  = BANK_W + FILE_W;
   localparam logic [FILE_W-1:0] SPLIT_F = FILE_W'(ACC_SPLIT);

   logic [ADDR_W-1:0] acc_addr;
   logic              acc_low;

   if (ACC_SPLIT <= 0 || ACC_SPLIT >= (1 << FILE_W)) begin : g_bad_split
      $error("dmag_direct_map: ACC_SPLIT outside file range");
   end

   assign acc_low = (file_i < SPLIT_F);

   always_comb begin
      if (acc_low) acc_addr = {{BANK_W{1'b0}}, file_i};
      else         acc_addr = {{BANK_W{1'b1}}, file_i};
   end

   assign addr_o = bank_sel_i ? {bank_i, file_i} : acc_addr;

endmodule

// File: rtl/dmag_index_add.sv
module dmag_index_add #(
   parameter int ADDR_W      = 12,
   parameter int FILE_W      = 8,
   parameter int ACC_SPLIT   = 'h60,
   parameter bit EXT_SUPPORT = 1'b1
) (
   input  logic              ext_en_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [FILE_W-1:0] file_i,
   output logic              hit_o,
   output logic [ADDR_W-1:0] sum_o
);
   localparam logic [FILE_W-1:0] SPLIT_F = FILE_W'(ACC_SPLIT);

   if (FILE_W >= ADDR_W) begin : g_bad_width
      $error("dmag_index_add: offset must be narrower than address");
   end

   if (EXT_SUPPORT) begin : g_idx
      logic [ADDR_W-1:0] off_ext;
      assign off_ext = {{(ADDR_W-FILE_W){1'b0}}, file_i};
      assign sum_o   = base_i + off_ext;
      assign hit_o   = ext_en_i && (file_i < SPLIT_F);
   end else begin : g_no_idx
      assign sum_o = '0;
      assign hit_o = 1'b0;
   end

endmodule

// File: rtl/dmag_ptr_mux.sv
module dmag_ptr_mux #(
   parameter int ADDR_W = 12
) (
   input  logic [1:0]        sel_i,
   input  logic [ADDR_W-1:0] p0_i,
   input  logic [ADDR_W-1:0] p1_i,
   input  logic [ADDR_W-1:0] p2_i,
   output logic [ADDR_W-1:0] ptr_o
);
   always_comb begin
      unique case (sel_i)
         2'd0:    ptr_o = p0_i;
         2'd1:    ptr_o = p1_i;
         default: ptr_o = p2_i;
      endcase
   end

endmodule

// File: rtl/dm_addr_gen.sv
module dm_addr_gen
   import dmag_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int FILE_W      = 8,
   parameter int BANK_W      = 4,
   parameter int ACC_SPLIT   = 'h60,
   parameter bit EXT_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_strb,
   input  logic              op_nomem,
   input  logic              op_ind,
   input  logic [1:0]        op_ind_sel,
   input  logic [FILE_W-1:0] op_file,
   input  logic              op_bank,
   input  logic              cfg_ext,
   input  logic [BANK_W-1:0] bank_reg,
   input  logic [ADDR_W-1:0] ptr0,
   input  logic [ADDR_W-1:0] ptr1,
   input  logic [ADDR_W-1:0] ptr2,
   output logic [ADDR_W-1:0] ea_addr,
   output logic [1:0]        ea_mode,
   output logic              ea_valid
);
   localparam logic [FILE_W-1:0] SPLIT_F = FILE_W'(ACC_SPLIT);

   if (ADDR_W != BANK_W + FILE_W) begin : g_bad_geom
      $error("dm_addr_gen: ADDR_W must equal BANK_W + FILE_W");
   end

   logic [ADDR_W-1:0] dir_addr, idx_addr, ind_addr, nxt_addr;
   logic              idx_hit;
   ea_mode_e          nxt_mode;

   dmag_direct_map #(.FILE_W(FILE_W), .BANK_W(BANK_W), .ACC_SPLIT(ACC_SPLIT)) u_dir (
      .file_i(op_file), .bank_i(bank_reg), .bank_sel_i(op_bank), .addr_o(dir_addr)
   );

   dmag_index_add #(.ADDR_W(ADDR_W), .FILE_W(FILE_W), .ACC_SPLIT(ACC_SPLIT),
                    .EXT_SUPPORT(EXT_SUPPORT)) u_idx (
      .ext_en_i(cfg_ext), .base_i(ptr2), .file_i(op_file), .hit_o(idx_hit), .sum_o(idx_addr)
   );

   dmag_ptr_mux #(.ADDR_W(ADDR_W)) u_ptr (
      .sel_i(op_ind_sel), .p0_i(ptr0), .p1_i(ptr1), .p2_i(ptr2), .ptr_o(ind_addr)
   );

   always_comb begin
      if (op_ind) begin
         nxt_mode = M_IND;
         nxt_addr = ind_addr;
      end else if (op_bank) begin
         nxt_mode = M_BANK;
         nxt_addr = dir_addr;
      end else if (idx_hit) begin
         nxt_mode = M_IDX;
         nxt_addr = idx_addr;
      end else begin
         nxt_mode = M_ACC;
         nxt_addr = dir_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_addr  <= '0;
         ea_mode  <= M_BANK;
         ea_valid <= 1'b0;
      end else if (op_strb) begin
         ea_valid <= !op_nomem;
         if (!op_nomem) begin
            ea_addr <= nxt_addr;
            ea_mode <= nxt_mode;
         end
      end
   end

   AST_NOMEM_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      op_strb && op_nomem |=> !ea_valid && $stable(ea_addr) && $stable(ea_mode)); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_strb |=> $stable(ea_addr) && $stable(ea_mode) && $stable(ea_valid)); // R8
   AST_NO_IDX_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      op_strb && !op_nomem && !cfg_ext |=> ea_mode != M_IDX); // R5
   AST_BANKED_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      op_strb && !op_nomem && !op_ind && op_bank |=>
      ea_mode == M_BANK && ea_addr == {$past(bank_reg), $past(op_file)}); // R2
   AST_HIGH_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      op_strb && !op_nomem && !op_ind && !op_bank && op_file >= SPLIT_F |=>
      ea_mode == M_ACC && ea_valid); // R3

endmodule

// File: tb/tb_dm_addr_gen.sv
`timescale 1ns/1ps
module tb_dm_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_strb = 1'b0, op_nomem = 1'b0, op_ind = 1'b0, op_bank = 1'b0, cfg_ext = 1'b0;
   logic [1:0]  op_ind_sel = '0;
   logic [7:0]  op_file = '0;
   logic [3:0]  bank_reg = '0;
   logic [11:0] ptr0 = '0, ptr1 = '0, ptr2 = '0;
   logic [11:0] ea_addr;
   logic [1:0]  ea_mode;
   logic        ea_valid;

   int checks = 0;
   int fails  = 0;

   typedef struct { logic [11:0] addr; logic [1:0] mode; logic valid; string req; } exp_t;
   exp_t        sb[$];
   logic [11:0] last_addr = '0;
   logic [1:0]  last_mode = '0;
   logic        last_valid = 1'b0;

   always #10 clk = ~clk;

   dm_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .op_strb(op_strb), .op_nomem(op_nomem), .op_ind(op_ind),
      .op_ind_sel(op_ind_sel), .op_file(op_file), .op_bank(op_bank), .cfg_ext(cfg_ext),
      .bank_reg(bank_reg), .ptr0(ptr0), .ptr1(ptr1), .ptr2(ptr2),
      .ea_addr(ea_addr), .ea_mode(ea_mode), .ea_valid(ea_valid)
   );

   task automatic cmp(string req, logic [11:0] ea, logic [1:0] em, logic ev);
      checks++;
      if (ea_addr !== ea || ea_mode !== em || ea_valid !== ev) begin
         fails++;
         $display("FAIL %s actual addr=%h mode=%0d valid=%0b expected addr=%h mode=%0d valid=%0b",
                  req, ea_addr, ea_mode, ea_valid, ea, em, ev);
      end
   endtask

   // driver: applies one strobed operation and predicts its result from the requirements
   task automatic drive(string req, bit nomem, bit ind, logic [1:0] sel, logic [7:0] f,
                        bit bank, bit ext, logic [3:0] br,
                        logic [11:0] p0, logic [11:0] p1, logic [11:0] p2);
      exp_t e;
      @(negedge clk);
      op_strb = 1'b1; op_nomem = nomem; op_ind = ind; op_ind_sel = sel; op_file = f;
      op_bank = bank; cfg_ext = ext; bank_reg = br; ptr0 = p0; ptr1 = p1; ptr2 = p2;
      if (nomem) begin
         e.addr = last_addr; e.mode = last_mode; e.valid = 1'b0;
      end else begin
         e.valid = 1'b1;
         if (ind) begin
            e.mode = 2'd3;
            e.addr = (sel == 2'd0) ? p0 : (sel == 2'd1) ? p1 : p2;
         end else if (bank) begin
            e.mode = 2'd0; e.addr = {br, f};
         end else if (ext && f <= 8'h5F) begin
            e.mode = 2'd2; e.addr = p2 + {4'h0, f};
         end else begin
            e.mode = 2'd1; e.addr = (f < 8'h60) ? {4'h0, f} : {4'hF, f};
         end
      end
      e.req = req;
      last_addr = e.addr; last_mode = e.mode; last_valid = e.valid;
      sb.push_back(e);
   endtask

   // monitor: pops one expectation per strobed edge
   initial begin
      forever begin
         @(posedge clk);
         if (rst_n && op_strb) begin
            @(negedge clk);
            if (sb.size() == 0) begin
               checks++; fails++;
               $display("FAIL R9 actual result with no queued item expected none");
            end else begin
               exp_t e;
               e = sb.pop_front();
               cmp(e.req, e.addr, e.mode, e.valid);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R9 watchdog expired actual running expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      cmp("R1 during reset", 12'h000, 2'd0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      cmp("R1 after reset", 12'h000, 2'd0, 1'b0);

      // banked, both configurations
      drive("R2 banked ext0", 0, 0, 2'd0, 8'h3C, 1, 0, 4'h5, 12'h111, 12'h222, 12'h333);
      drive("R2 banked ext1 low file", 0, 0, 2'd0, 8'h10, 1, 1, 4'hA, 12'h111, 12'h222, 12'h333);
      // access mapping
      drive("R3 access low", 0, 0, 2'd0, 8'h5F, 0, 0, 4'h7, 12'h111, 12'h222, 12'h333);
      drive("R3 access high", 0, 0, 2'd0, 8'h60, 0, 0, 4'h7, 12'h111, 12'h222, 12'h333);
      drive("R3 access high ext1", 0, 0, 2'd0, 8'h60, 0, 1, 4'h7, 12'h111, 12'h222, 12'h400);
      drive("R3 access top ext1", 0, 0, 2'd0, 8'hFF, 0, 1, 4'h7, 12'h111, 12'h222, 12'h400);
      // indexed
      drive("R4 indexed zero", 0, 0, 2'd0, 8'h00, 0, 1, 4'h7, 12'h111, 12'h222, 12'h400);
      drive("R4 indexed edge", 0, 0, 2'd0, 8'h5F, 0, 1, 4'h7, 12'h111, 12'h222, 12'h400);
      drive("R4 indexed wrap", 0, 0, 2'd0, 8'h20, 0, 1, 4'h7, 12'h111, 12'h222, 12'hFF0);
      // extended off
      drive("R5 ext0 low file", 0, 0, 2'd0, 8'h10, 0, 0, 4'h7, 12'h111, 12'h222, 12'h800);
      // indirect
      drive("R6 ind sel0", 0, 1, 2'd0, 8'h10, 0, 1, 4'h7, 12'hABC, 12'h456, 12'h789);
      drive("R6 ind sel1", 0, 1, 2'd1, 8'h10, 1, 0, 4'h7, 12'hABC, 12'h456, 12'h789);
      drive("R6 ind sel2", 0, 1, 2'd2, 8'h10, 0, 1, 4'h7, 12'hABC, 12'h456, 12'h789);
      drive("R6 ind sel3", 0, 1, 2'd3, 8'h70, 0, 0, 4'h7, 12'hABC, 12'h456, 12'h789);
      // no operand, and priority over indirect
      drive("R7 nomem", 1, 0, 2'd0, 8'h22, 1, 0, 4'h9, 12'h111, 12'h222, 12'h333);
      drive("R9 valid again", 0, 0, 2'd0, 8'h22, 1, 0, 4'h9, 12'h111, 12'h222, 12'h333);
      drive("R10 nomem over ind", 1, 1, 2'd1, 8'h22, 1, 1, 4'h9, 12'h111, 12'h222, 12'h333);
      drive("R10 ind over banked", 0, 1, 2'd1, 8'h22, 1, 1, 4'h9, 12'h111, 12'hBEE, 12'h333);
      drive("R10 banked over indexed", 0, 0, 2'd0, 8'h05, 1, 1, 4'hC, 12'h111, 12'h222, 12'h333);

      // idle: change every input with the strobe low
      @(negedge clk);
      op_strb = 1'b0; op_nomem = 1'b0; op_ind = 1'b0; op_bank = 1'b0; cfg_ext = 1'b1;
      op_file = 8'h01; bank_reg = 4'h3; ptr2 = 12'h777;
      repeat (3) @(negedge clk);
      cmp("R8 hold without strobe", last_addr, last_mode, last_valid);
      op_nomem = 1'b1; op_ind = 1'b1;
      repeat (2) @(negedge clk);
      cmp("R8 hold with nomem low strobe", last_addr, last_mode, last_valid);

      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         checks++; fails++;
         $display("FAIL R9 actual %0d items pending expected 0", sb.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule